// File: doc/BRIEF.md
# Edge/Level Interrupt Request Tracker

This block keeps the request state for a set of interrupt pins and turns it into delivery requests for a single downstream acceptor. Line-state changes arrive as per-pin report pulses: `line_set` reports that a pin's input is asserted and `line_clr` that it is deasserted. Each pin is configured live with a trigger mode, a mask, a vector and a destination. A pin that needs service is offered to the acceptor together with its vector, destination and trigger mode, through a valid/ready handshake.

Edge pins and level pins decide differently when a new assertion is redundant. An edge pin's assertion is redundant when its request bit is still set from before. A level pin's assertion is redundant while the pin waits for an end-of-interrupt. In either case the block flags the assertion as coalesced for one cycle and starts no delivery for it.

When a level pin's delivery is accepted, the pin's remote-pending flag is set. The flag stays set until that pin's `eoi` input is pulsed. When an edge pin's delivery is accepted, the pin is marked delivered. A delivered pin is hidden from the request view until it is asserted again after a deassertion.

Top module: `irq_req_tracker`

## Requirements
- R1: A `line_clr` pulse clears the pin's request bit, so `pend_view` drops for that pin after the next clock edge. When `line_set` and `line_clr` reach the same pin in the same cycle, the clear wins and no coalesced flag is raised.
- R2: On an edge pin (`trig_level` bit = 0), a `line_set` pulse that arrives while the request bit is already set raises `coalesced` for that pin for one cycle after the edge. That pulse starts no new delivery.
- R3: On a level pin (`trig_level` bit = 1), a `line_set` pulse that arrives while remote-pending is set raises `coalesced` for one cycle and is not delivered. The request bit is still recorded. Once `eoi` clears remote-pending, the pin is offered again.
- R4: A pin whose `mask` bit is 1 is never offered, and its request bit stays visible in `pend_view`. After the pin is unmasked, it is offered.
- R5: An accepted delivery of a level pin sets that pin's `remote_pend` bit after the accepting edge. An `eoi` pulse for the pin clears it after the next edge.
- R6: An accepted delivery of an edge pin hides that pin from `pend_view` while its request bit stays set. A later `line_set` on it is therefore coalesced.
- R7: A `line_set` on an edge pin whose request bit is clear clears the pin's delivered mark. The pin becomes visible in `pend_view` again and can be offered again.
- R8: When several pins are eligible, the lowest-numbered unmasked one is offered. `out_pin`, `out_vector`, `out_dest` and `out_level` carry that pin's number, its `vec_tbl` slice (bits pin*VEC_W upward), its `dst_tbl` slice and its trigger mode.
- R9: `out_valid` rises one cycle after a pin becomes eligible. While `out_ready` is low, the offer holds with unchanged fields. Each handshake (`out_valid` and `out_ready` both high at a clock edge) delivers exactly once, and `out_valid` then drops for at least one cycle.
- R10: While `rst_n` is low, all request, delivered and remote-pending state, the coalesced flags and the offer are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_set | input | NPINS | Per-pin assertion report pulse |
| line_clr | input | NPINS | Per-pin deassertion report pulse |
| trig_level | input | NPINS | Trigger mode per pin, 1 = level, 0 = edge |
| mask | input | NPINS | Per-pin delivery mask, 1 = masked |
| vec_tbl | input | NPINS*VEC_W | Vector per pin, pin i at bits i*VEC_W |
| dst_tbl | input | NPINS*DEST_W | Destination per pin, pin i at bits i*DEST_W |
| eoi | input | NPINS | Per-pin end-of-interrupt pulse |
| out_valid | output | 1 | Delivery request valid |
| out_ready | input | 1 | Acceptor takes the request |
| out_pin | output | PIN_W | Pin number of the offered request |
| out_vector | output | VEC_W | Vector of the offered request |
| out_dest | output | DEST_W | Destination of the offered request |
| out_level | output | 1 | Trigger mode of the offered request |
| pend_view | output | NPINS | Request bits with delivered edge pins hidden |
| remote_pend | output | NPINS | Per-pin remote-pending flags |
| coalesced | output | NPINS | One-cycle flag for a coalesced assertion |

## Verification
Report pulses, `eoi` pulses and mask changes take effect at the first clock edge after they are driven. `pend_view`, `remote_pend` and `coalesced` therefore change right after that edge. An offer appears one edge later, because it is loaded from the registered request state. Its acceptance lands at the edge where `out_ready` is sampled high, and from that edge on `out_valid` drops and the remote-pending flag or the hiding of the pin shows. The bench drives every input at the falling edge and samples at the next falling edge, one rising edge later. Each row of its table states what must be visible after exactly that one edge. Multi-cycle behaviour, such as the load of an offer followed by its acceptance, is written as consecutive rows.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;

    // Per-pin tracking state
    typedef struct packed {
        logic req;     // request bit
        logic dlvd;    // edge delivery done, hides the request
        logic rpend;   // level delivery awaiting end-of-interrupt
        logic coal;    // last assertion was coalesced (one-cycle flag)
    } pin_st_t;

    localparam pin_st_t PIN_ST_RESET = '{req: 1'b0, dlvd: 1'b0, rpend: 1'b0, coal: 1'b0};

endpackage

// File: rtl/irq_trk_pick.sv
module irq_trk_pick #(
    parameter int NPINS = 8,
    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic [NPINS-1:0] cand,
    output logic             any,
    output logic [PIN_W-1:0] idx
);

    // Lowest index wins: scan from the top so the lowest assignment stays.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NPINS - 1; i >= 0; i--) begin
            if (cand[i]) begin
                any = 1'b1;
                idx = PIN_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_trk_pin.sv
module irq_trk_pin
    import irq_trk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic level_i,
    input  logic mask_i,
    input  logic eoi_i,
    input  logic acc_i,
    input  logic acc_level_i,
    output logic eligible_o,
    output logic view_o,
    output logic rpend_o,
    output logic coal_o
);

    pin_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.coal = 1'b0;
        if (clr_i) begin
            st_d.req = 1'b0;
        end else if (set_i) begin
            st_d.req = 1'b1;
            if (level_i) begin
                st_d.coal = st_q.rpend;
            end else begin
                st_d.coal = st_q.req;
                if (!st_q.req) st_d.dlvd = 1'b0;
            end
        end
        if (eoi_i) st_d.rpend = 1'b0;
        if (acc_i) begin
            if (acc_level_i) st_d.rpend = 1'b1;
            else             st_d.dlvd  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PIN_ST_RESET;
        else        st_q <= st_d;
    end

    assign eligible_o = st_q.req && !mask_i && (level_i ? !st_q.rpend : !st_q.dlvd);
    assign view_o     = st_q.req && !st_q.dlvd;
    assign rpend_o    = st_q.rpend;
    assign coal_o     = st_q.coal;

endmodule

// File: rtl/irq_trk_offer.sv
module irq_trk_offer #(
    parameter int NPINS  = 8,
    parameter int VEC_W  = 8,
    parameter int DEST_W = 8,
    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPINS-1:0]        eligible,
    input  logic [NPINS-1:0]        trig_level,
    input  logic [NPINS*VEC_W-1:0]  vec_tbl,
    input  logic [NPINS*DEST_W-1:0] dst_tbl,
    input  logic                    ready,
    output logic                    valid,
    output logic [PIN_W-1:0]        pin,
    output logic [VEC_W-1:0]        vector,
    output logic [DEST_W-1:0]       dest,
    output logic                    level,
    output logic [NPINS-1:0]        acc
);

    typedef struct packed {
        logic              valid;
        logic [PIN_W-1:0]  pin;
        logic [VEC_W-1:0]  vector;
        logic [DEST_W-1:0] dest;
        logic              level;
    } offer_t;

    offer_t of_d, of_q;
    logic             pick_any;
    logic [PIN_W-1:0] pick_idx;

    irq_trk_pick #(.NPINS(NPINS)) u_pick (
        .cand (eligible),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    always_comb begin
        of_d = of_q;
        if (of_q.valid) begin
            if (ready) of_d.valid = 1'b0;
        end else if (pick_any) begin
            of_d.valid  = 1'b1;
            of_d.pin    = pick_idx;
            of_d.vector = vec_tbl[pick_idx*VEC_W +: VEC_W];
            of_d.dest   = dst_tbl[pick_idx*DEST_W +: DEST_W];
            of_d.level  = trig_level[pick_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) of_q <= '0;
        else        of_q <= of_d;
    end

    always_comb begin
        acc = '0;
        if (of_q.valid && ready) acc[of_q.pin] = 1'b1;
    end

    assign valid  = of_q.valid;
    assign pin    = of_q.pin;
    assign vector = of_q.vector;
    assign dest   = of_q.dest;
    assign level  = of_q.level;

endmodule

// File: rtl/irq_req_tracker.sv
module irq_req_tracker #(
    parameter int NPINS  = 8,
    parameter int VEC_W  = 8,
    parameter int DEST_W = 8,
    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPINS-1:0]        line_set,
    input  logic [NPINS-1:0]        line_clr,
    input  logic [NPINS-1:0]        trig_level,
    input  logic [NPINS-1:0]        mask,
    input  logic [NPINS*VEC_W-1:0]  vec_tbl,
    input  logic [NPINS*DEST_W-1:0] dst_tbl,
    input  logic [NPINS-1:0]        eoi,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [PIN_W-1:0]        out_pin,
    output logic [VEC_W-1:0]        out_vector,
    output logic [DEST_W-1:0]       out_dest,
    output logic                    out_level,
    output logic [NPINS-1:0]        pend_view,
    output logic [NPINS-1:0]        remote_pend,
    output logic [NPINS-1:0]        coalesced
);

    logic [NPINS-1:0] eligible;
    logic [NPINS-1:0] acc;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        irq_trk_pin u_pin (
            .clk         (clk),
            .rst_n       (rst_n),
            .set_i       (line_set[g]),
            .clr_i       (line_clr[g]),
            .level_i     (trig_level[g]),
            .mask_i      (mask[g]),
            .eoi_i       (eoi[g]),
            .acc_i       (acc[g]),
            .acc_level_i (out_level),
            .eligible_o  (eligible[g]),
            .view_o      (pend_view[g]),
            .rpend_o     (remote_pend[g]),
            .coal_o      (coalesced[g])
        );
    end

    irq_trk_offer #(.NPINS(NPINS), .VEC_W(VEC_W), .DEST_W(DEST_W)) u_offer (
        .clk        (clk),
        .rst_n      (rst_n),
        .eligible   (eligible),
        .trig_level (trig_level),
        .vec_tbl    (vec_tbl),
        .dst_tbl    (dst_tbl),
        .ready      (out_ready),
        .valid      (out_valid),
        .pin        (out_pin),
        .vector     (out_vector),
        .dest       (out_dest),
        .level      (out_level),
        .acc        (acc)
    );

endmodule

// File: rtl/irq_req_tracker_chk.sv
module irq_req_tracker_chk #(
    parameter int NPINS = 8,
    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] line_set,
    input logic [NPINS-1:0] line_clr,
    input logic [NPINS-1:0] mask,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PIN_W-1:0] out_pin,
    input logic             out_level,
    input logic [NPINS-1:0] pend_view,
    input logic [NPINS-1:0] remote_pend,
    input logic [NPINS-1:0] coalesced
);

    logic [NPINS-1:0] mask_q;
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask;
    end

    // R9: a held offer keeps its pin until taken
    assert_offer_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pin));

    // R5: remote-pending only appears after an accepted level delivery
    assert_rpend_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(remote_pend & ~$past(remote_pend))) |-> $past(out_valid && out_ready && out_level));

    // R4: a newly loaded offer never names a pin that was masked when loaded
    assert_no_masked_offer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> !mask_q[out_pin]);

    // R2: a coalesced flag needs an assertion report one edge earlier
    assert_coal_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (coalesced & ~$past(line_set)) == '0);

    // R1: a deassertion report leaves no visible request
    assert_clear_view_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_view & $past(line_clr)) == '0);

endmodule

bind irq_req_tracker irq_req_tracker_chk #(.NPINS(NPINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_set    (line_set),
    .line_clr    (line_clr),
    .mask        (mask),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_pin     (out_pin),
    .out_level   (out_level),
    .pend_view   (pend_view),
    .remote_pend (remote_pend),
    .coalesced   (coalesced)
);

// File: tb/test_irq_req_tracker.sv
module test_irq_req_tracker;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   line_set = '0, line_clr = '0, mask = '0, eoi = '0;
    logic [NP-1:0]   trig_level = 4'b0011;   // pins 0,1 level; 2,3 edge
    logic [NP*8-1:0] vec_tbl = {8'h23, 8'h22, 8'h21, 8'h20};
    logic [NP*8-1:0] dst_tbl = {8'h43, 8'h42, 8'h41, 8'h40};
    logic            out_ready = 1'b0;
    logic            out_valid, out_level;
    logic [1:0]      out_pin;
    logic [7:0]      out_vector, out_dest;
    logic [NP-1:0]   pend_view, remote_pend, coalesced;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_req_tracker #(.NPINS(NP), .VEC_W(8), .DEST_W(8)) i_irq_req_tracker (
        .clk(clk), .rst_n(rst_n), .line_set(line_set), .line_clr(line_clr),
        .trig_level(trig_level), .mask(mask), .vec_tbl(vec_tbl), .dst_tbl(dst_tbl),
        .eoi(eoi), .out_valid(out_valid), .out_ready(out_ready), .out_pin(out_pin),
        .out_vector(out_vector), .out_dest(out_dest), .out_level(out_level),
        .pend_view(pend_view), .remote_pend(remote_pend), .coalesced(coalesced)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [3:0] set, clr, eoi, msk;
        logic       rdy;
        logic       val;
        logic [1:0] pin;
        logic [3:0] coal, view, rp;
    } row_t;

    localparam int NROWS = 25;
    localparam row_t TBL [NROWS] = '{
        // set     clr      eoi      msk    rdy  val pin  coal     view     rp
        '{4'b0001, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 2'd0, 4'b0000, 4'b0001, 4'b0000}, // R9 no offer yet
        '{4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b1, 2'd0, 4'b0000, 4'b0001, 4'b0000}, // R9 offer rises
        '{4'b0001, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b1, 2'd0, 4'b0000, 4'b0001, 4'b0000}, // R9 held
        '{4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b0, 2'd0, 4'b0000, 4'b0001, 4'b0001}, // R5 rpend set
        '{4'b0001, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b0, 2'd0, 4'b0001, 4'b0001, 4'b0001}, // R3 coalesced
        '{4'b0000, 4'b0000, 4'b0001, 4'b0000, 1'b1, 1'b0, 2'd0, 4'b0000, 4'b0001, 4'b0000}, // R5 eoi clears
        '{4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b1, 2'd0, 4'b0000, 4'b0001, 4'b0000}, // R3 reoffered
        '{4'b0000, 4'b0001, 4'b0000, 4'b0000, 1'b1, 1'b0, 2'd0, 4'b0000, 4'b0000, 4'b0001}, // R1 clear
        '{4'b0000, 4'b0000, 4'b0001, 4'b0000, 1'b0, 1'b0, 2'd0, 4'b0000, 4'b0000, 4'b0000}, // R5
        '{4'b0100, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 2'd0, 4'b0000, 4'b0100, 4'b0000}, // R7 edge set
        '{4'b0100, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b1, 2'd2, 4'b0100, 4'b0100, 4'b0000}, // R2 coalesced
        '{4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b0, 2'd0, 4'b0000, 4'b0000, 4'b0000}, // R6 hidden
        '{4'b0100, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b0, 2'd0, 4'b0100, 4'b0000, 4'b0000}, // R6 R2 coalesced
        '{4'b0000, 4'b0100, 4'b0000, 4'b0000, 1'b0, 1'b0, 2'd0, 4'b0000, 4'b0000, 4'b0000}, // R1
        '{4'b0100, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 2'd0, 4'b0000, 4'b0100, 4'b0000}, // R7 visible
        '{4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b1, 2'd2, 4'b0000, 4'b0100, 4'b0000}, // R7 reoffered
        '{4'b0000, 4'b0100, 4'b0000, 4'b0000, 1'b1, 1'b0, 2'd0, 4'b0000, 4'b0000, 4'b0000}, // R9 one delivery
        '{4'b1110, 4'b0000, 4'b0000, 4'b0010, 1'b0, 1'b0, 2'd0, 4'b0000, 4'b1110, 4'b0000}, // R4 masked visible
        '{4'b0000, 4'b0000, 4'b0000, 4'b0010, 1'b0, 1'b1, 2'd2, 4'b0000, 4'b1110, 4'b0000}, // R8 R4 skip pin1
        '{4'b0000, 4'b0000, 4'b0000, 4'b0010, 1'b1, 1'b0, 2'd0, 4'b0000, 4'b1010, 4'b0000}, // R6
        '{4'b0000, 4'b0000, 4'b0000, 4'b0010, 1'b1, 1'b1, 2'd3, 4'b0000, 4'b1010, 4'b0000}, // R8 next pin
        '{4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b0, 2'd0, 4'b0000, 4'b0010, 4'b0000}, // R6
        '{4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b1, 2'd1, 4'b0000, 4'b0010, 4'b0000}, // R4 unmasked offer
        '{4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b0, 2'd0, 4'b0000, 4'b0010, 4'b0010}, // R5
        '{4'b0000, 4'b1110, 4'b0010, 4'b0000, 1'b0, 1'b0, 2'd0, 4'b0000, 4'b0000, 4'b0000}  // R1 R5
    };

    task automatic step(logic [3:0] s, logic [3:0] c, logic [3:0] e, logic [3:0] m, logic r);
        line_set = s; line_clr = c; eoi = e; mask = m; out_ready = r;
        @(posedge clk);
        @(negedge clk);
        line_set = '0; line_clr = '0; eoi = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk("R10 valid", 32'(out_valid), 0);
        chk("R10 view", 32'(pend_view), 0);
        chk("R10 rpend", 32'(remote_pend), 0);
        chk("R10 coal", 32'(coalesced), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NROWS; i++) begin
            step(TBL[i].set, TBL[i].clr, TBL[i].eoi, TBL[i].msk, TBL[i].rdy);
            chk($sformatf("row%0d valid", i), 32'(out_valid), 32'(TBL[i].val));
            chk($sformatf("row%0d coal", i), 32'(coalesced), 32'(TBL[i].coal));
            chk($sformatf("row%0d view", i), 32'(pend_view), 32'(TBL[i].view));
            chk($sformatf("row%0d rpend", i), 32'(remote_pend), 32'(TBL[i].rp));
            if (TBL[i].val) begin
                // R8 offer fields follow the pin
                chk($sformatf("R8 row%0d pin", i), 32'(out_pin), 32'(TBL[i].pin));
                chk($sformatf("R8 row%0d vector", i), 32'(out_vector), 32'h20 + 32'(TBL[i].pin));
                chk($sformatf("R8 row%0d dest", i), 32'(out_dest), 32'h40 + 32'(TBL[i].pin));
                chk($sformatf("R8 row%0d level", i), 32'(out_level), 32'(TBL[i].pin < 2));
            end
        end

        // R1: set and clear together, clear wins
        step(4'b0001, 4'b0001, 4'b0000, 4'b0000, 1'b0);
        chk("R1 same-cycle view", 32'(pend_view), 0);
        chk("R1 same-cycle coal", 32'(coalesced), 0);
        step(4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0);
        chk("R1 same-cycle no offer", 32'(out_valid), 0);

        // R10: reset with live state
        step(4'b0001, 4'b0000, 4'b0000, 4'b0000, 1'b0);
        step(4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0);
        step(4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1);
        chk("R10 pre-reset rpend", 32'(remote_pend), 1);
        rst_n = 1'b0;
        step(4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0);
        chk("R10 rpend cleared", 32'(remote_pend), 0);
        chk("R10 view cleared", 32'(pend_view), 0);
        chk("R10 offer cleared", 32'(out_valid), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule